// File: doc/BRIEF.md
# Chained quad-DAC refresh loader

This block drives a single serial port that feeds three quad-channel 8-bit DAC chips. The data line runs through the chips one after another, while the serial clock, the load strobe and the active-low chip select reach all three chips in parallel. Because of this wiring, one chip cannot be updated alone. The block therefore keeps a shadow copy of all twelve channel values. A host sets those values with single-cycle write strobes.

After every accepted write, the block sends the whole configuration again. It sends four 36-bit frames, one for each channel letter from A to D. Each frame carries one 12-bit word per chip and is followed by a load strobe that latches all three chips together. A busy flag covers the whole refresh, and a one-cycle done pulse marks its end. A write that arrives while a refresh is running is remembered and causes exactly one more full refresh afterwards.

Top module: `dac_chain_loader`

## Requirements
- R1: After reset, cs_n is 1 and load, sclk, busy and done are all 0. Every shadow value is 0x00.
- R2: A write with wr_en high and wr_chip below 3 stores wr_data as the value of channel wr_chan on chip wr_chip. It then starts a refresh of exactly four frames, sent in the order A, B, C, D (wr_chan 0 to 3), with exactly one load pulse after each frame.
- R3: Each chip word is 12 bits wide: the 2-bit channel index, then the constant 2'b11, then the 8-bit value. It is sent MSB first, so A is 0011, B is 0111, C is 1011 and D is 1111.
- R4: Inside a frame, the word for chip 2 (the chip farthest down the chain) is sent first and the word for chip 0 is sent last. Each frame is therefore exactly 36 bits long.
- R5: cs_n stays low for the whole of a frame, and sclk pulses only while cs_n is low. sdata changes only while sclk is low, and the chips sample it on the rising edge of sclk. One serial bit lasts 2*HALF system clocks.
- R6: After each frame, load is high for exactly 2*HALF system clocks while cs_n is high and sclk is low.
- R7: busy is high from the start of a refresh until the end of its last load pulse. done is then high for exactly one cycle, in the first cycle in which busy is low.
- R8: Any number of writes accepted during a refresh cause exactly one extra full refresh. That refresh carries the newly written values.
- R9: Every write starts a refresh, including one that rewrites an unchanged value. The values 0x00 and 0xFF are sent unaltered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_chip | input | 2 | Chip position in the chain (0 = nearest to sdata) |
| wr_chan | input | 2 | Channel index, 0..3 = A..D |
| wr_data | input | 8 | New 8-bit channel value |
| sclk | output | 1 | Serial clock to all chips |
| sdata | output | 1 | Serial data into the head of the chain |
| cs_n | output | 1 | Active-low chip select to all chips |
| load | output | 1 | Load strobe to all chips |
| busy | output | 1 | Refresh in progress |
| done | output | 1 | One-cycle pulse at the end of a refresh |

## Verification
The bench collects each frame from the serial lines and compares it with a model of the shadow values. A chip order reversed inside a frame would place every value in the wrong chip. A wrong channel prefix, or an LSB-first word, would show up as a mismatch in the word's upper four bits.

Writes are issued during the third frame of a refresh. The test checks that exactly one additional refresh follows and that it carries the new data. A design that drops such a write, or that restarts once per write, gives the wrong frame count.

Further checks cover the load pulse width, the moment done appears relative to busy, and a rewrite of an unchanged value. These target a strobe that is too short, a done that overlaps busy, and a loader that skips refreshes it considers redundant.

// File: rtl/dac_chain_loader.sv
module dac_chain_loader #(
  parameter int NCHIP = 3,
  parameter int DW    = 8,
  parameter int HALF  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_chip,
  input  logic [1:0] wr_chan,
  input  logic [7:0] wr_data,
  output logic       sclk,
  output logic       sdata,
  output logic       cs_n,
  output logic       load,
  output logic       busy,
  output logic       done
);
  localparam int NCH  = 4;
  localparam int WORD = DW + 4;
  localparam int FW   = NCHIP * WORD;
  localparam int BW   = $clog2(FW);
  localparam int PW   = 2 * HALF;
  localparam int DVW  = $clog2(PW) + 1;

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_SHIFT, S_LOAD} st_t;

  st_t            state;
  logic [DW-1:0]  shadow [NCHIP][NCH];
  logic [FW-1:0]  shreg, frame_word;
  logic [BW-1:0]  bitcnt;
  logic [DVW-1:0] div;
  logic [1:0]     frame;
  logic           pending, done_q, wrap, wr_hit;

  assign wr_hit = wr_en && ({1'b0, wr_chip} < 3'(NCHIP));
  assign wrap   = div == DVW'(PW - 1);
  assign busy   = state != S_IDLE;
  assign cs_n   = state != S_SHIFT;
  assign load   = state == S_LOAD;
  assign sclk   = (state == S_SHIFT) && (div >= DVW'(HALF));
  assign sdata  = (state == S_SHIFT) ? shreg[FW-1] : 1'b0;
  assign done   = done_q;

  always_comb begin
    frame_word = '0;
    for (int k = 0; k < NCHIP; k++)
      frame_word[k*WORD +: WORD] = {frame, 2'b11, shadow[k][frame]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCHIP; k++)
        for (int c = 0; c < NCH; c++)
          shadow[k][c] <= '0;
    end else if (wr_hit) begin
      shadow[wr_chip][wr_chan] <= wr_data[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      div     <= '0;
      frame   <= '0;
      pending <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy && wr_hit) pending <= 1'b1;
      case (state)
        S_IDLE: if (wr_hit || pending) begin
          state   <= S_PREP;
          frame   <= '0;
          pending <= 1'b0;
        end
        S_PREP: begin
          shreg  <= frame_word;
          bitcnt <= '0;
          div    <= '0;
          state  <= S_SHIFT;
        end
        S_SHIFT: begin
          div <= wrap ? '0 : div + 1'b1;
          if (wrap) begin
            if (bitcnt == BW'(FW - 1)) state <= S_LOAD;
            else begin
              shreg  <= {shreg[FW-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: begin
          div <= wrap ? '0 : div + 1'b1;
          if (wrap) begin
            if (frame == 2'd3) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              frame <= frame + 1'b1;
              state <= S_PREP;
            end
          end
        end
      endcase
    end
  end

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_load_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cs_n && !sclk));
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));
  p_frame_end_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> load);
  p_pending_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pending) |=> busy);
endmodule

// File: tb/dac_chain_loader_tb_top.sv
module dac_chain_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int PW = 2 * HALF;
  localparam int NV = 6;
  localparam logic [11:0] VEC [NV] = '{
    {2'd0, 2'd0, 8'h5A}, {2'd1, 2'd1, 8'hC3}, {2'd2, 2'd3, 8'hFF},
    {2'd2, 2'd0, 8'h81}, {2'd0, 2'd3, 8'h00}, {2'd1, 2'd2, 8'h3C}};

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_chip = 0, wr_chan = 0;
  logic [7:0] wr_data = 0;
  logic sclk, sdata, cs_n, load, busy, done;

  logic [7:0]  model [3][4];
  logic [35:0] fr [16];
  int          fbits [16];
  logic [35:0] cap;
  int nbits = 0, nf = 0, ndone = 0, lw_run = 0, lw_last = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_chain_loader #(.NCHIP(3), .DW(8), .HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chip(wr_chip),
    .wr_chan(wr_chan), .wr_data(wr_data), .sclk(sclk), .sdata(sdata),
    .cs_n(cs_n), .load(load), .busy(busy), .done(done));

  always @(posedge sclk) if (!cs_n) begin cap = {cap[34:0], sdata}; nbits++; end
  always @(posedge load) begin
    if (nf < 16) begin fr[nf] = cap; fbits[nf] = nbits; end
    nf++; nbits = 0;
  end
  always @(posedge done) ndone++;
  always @(negedge clk) begin
    if (load) lw_run++;
    else if (lw_run != 0) begin lw_last = lw_run; lw_run = 0; end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_frame(input int c);
    logic [35:0] f = '0;
    for (int k = 2; k >= 0; k--) f = {f[23:0], 2'(c), 2'b11, model[k][c]};
    return f;
  endfunction

  task automatic do_write(input logic [1:0] ch, input logic [1:0] cn, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_chip = ch; wr_chan = cn; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_done;
    do @(negedge clk); while (!done);
  endtask

  task automatic check_frames(input int base, input string req);
    for (int c = 0; c < 4; c++) begin
      check(fr[base+c] == exp_frame(c), req, fr[base+c], exp_frame(c));
      check(fbits[base+c] == 36, "R4 frame length", fbits[base+c], 36);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) for (int c = 0; c < 4; c++) model[k][c] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({cs_n, load, sclk, busy, done} == 5'b10000, "R1 reset outputs",
          {cs_n, load, sclk, busy, done}, 5'b10000);

    // R2 R3 R4 vector table walk
    for (int v = 0; v < NV; v++) begin
      nf = 0;
      model[VEC[v][11:10]][VEC[v][9:8]] = VEC[v][7:0];
      do_write(VEC[v][11:10], VEC[v][9:8], VEC[v][7:0]);
      wait_done();
      check(nf == 4, "R2 loads per refresh", nf, 4);
      check_frames(0, "R3/R4 frame content");
    end

    // R6 load width
    check(lw_last == PW, "R6 load width", lw_last, PW);

    // R7 done follows busy, one cycle wide
    nf = 0;
    do_write(2'd1, 2'd0, 8'h11); model[1][0] = 8'h11;
    begin
      bit prev_busy = 1;
      do begin @(negedge clk); if (!done) prev_busy = busy; end while (!done);
      check(!busy && prev_busy, "R7 done after busy", {busy, prev_busy}, 2'b01);
      @(negedge clk);
      check(done == 0, "R7 done width", done, 0);
    end

    // R9 rewrite of unchanged value still refreshes
    nf = 0;
    do_write(2'd1, 2'd0, 8'h11);
    wait_done();
    check(nf == 4, "R9 same-value refresh", nf, 4);
    check_frames(0, "R9 frame content");

    // R5 idle serial lines after refresh
    check({cs_n, sclk} == 2'b10, "R5 idle lines", {cs_n, sclk}, 2'b10);

    // R8 writes during refresh collapse into one extra refresh
    nf = 0; ndone = 0;
    model[0][2] = 8'h77;
    do_write(2'd0, 2'd2, 8'h77);
    while (nf < 2) @(negedge clk);
    begin
      logic [35:0] e0, e1, e2, e3;
      e0 = exp_frame(0); e1 = exp_frame(1); e2 = exp_frame(2); e3 = exp_frame(3);
      do_write(2'd0, 2'd0, 8'hE1);
      do_write(2'd2, 2'd0, 8'h2E);
      model[0][0] = 8'hE1; model[2][0] = 8'h2E;
      wait_done();
      check(fr[0] == e0, "R8 first refresh A", fr[0], e0);
      check(fr[1] == e1, "R8 first refresh B", fr[1], e1);
      check(fr[2] == e2, "R8 first refresh C", fr[2], e2);
      check(fr[3] == e3, "R8 first refresh D", fr[3], e3);
      wait_done();
      repeat (50) @(negedge clk);
      check(ndone == 2, "R8 refresh count", ndone, 2);
      check(nf == 8, "R8 load count", nf, 8);
      check(busy == 0, "R8 idle after extra refresh", busy, 0);
      check_frames(4, "R8 second refresh content");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule